// File: doc/BRIEF.md
# EEPROM Command Transaction Sequencer

This block is the byte-level transaction engine of an I2C slave that owns a 256-byte non-volatile array and a separate 6-bit configuration word. A bit-level front end reports start (or repeated start), stop and each received byte. It takes the acknowledge decision back from this block, and pulls transmit bytes from it. Each write transaction carries the slave address, then a command byte, then (for memory commands) an address byte, then data. Reads reuse the command and address of the preceding write phase after a repeated start.

Array writes collect up to one page of bytes in a page buffer. Programming starts at stop. While it lasts, the block is busy and refuses its own address. A write-protect input taken at stop discards the pending write. Combined commands move an array byte into one of the three GPIO control registers, which live outside the block, or store the GPIO input value into the array. A further command snapshots the five mux inputs.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: An address byte is acknowledged only when its upper seven bits equal 100111 followed by the `a0` pin value and the block is not busy. Bit 0 selects read (1) or write (0). Otherwise every byte is ignored up to the next start.
- R2: After command 0x01 and an address byte, each data byte goes to the current address. The low four address bits then step modulo 16 and the upper four stay fixed.
- R3: After command 0x03 and an address, a read phase returns the array byte at the pointer. Each `tx_take` advances the full 8-bit pointer, and 0xFF wraps to 0x00.
- R4: A stop that ends a transaction with pending write data and `wp`=0 raises `busy` for exactly PROG_CYCLES cycles, and the data lands when it falls. While `busy` is 1, a matching address byte gets no acknowledge.
- R5: When `wp` is 1 at stop, pending writes are discarded: `busy` stays 0 and both memories keep their contents.
- R6: Command 0x04 with an address byte stores bits [5:0] of the next data byte in the 6-bit word. Command 0x06 then reads it back as {2'b00, word}.
- R7: Commands 0x0F, 0x10 and 0x11 pulse `gpio_ld` bit 0 (output), bit 1 (polarity) and bit 2 (direction) respectively. The pulse lasts one cycle and comes in the cycle after the address byte, with `gpio_ld_data` equal to the array byte at that address.
- R8: Command 0x12 samples `gpio_in` at the address byte and writes it to that array address after stop. The following dummy byte has no effect.
- R9: Command 0x0C latches `mux_in` at the command byte. A following read returns {3'b000, latched value}, and later input changes are not seen.
- R10: Any other command code is acknowledged with its data bytes, has no effect on memory, and reads as 0xFF.
- R11: After reset, `busy` and `gpio_ld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a0 | input | 1 | Address select pin value |
| wp | input | 1 | Write protect, 1 blocks programming |
| mux_in | input | 5 | Mux input pins |
| gpio_in | input | 8 | GPIO input register value |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| rx_valid | input | 1 | A received byte is presented |
| rx_byte | input | 8 | Received byte |
| rx_ack | output | 1 | Acknowledge decision for the presented byte |
| tx_take | input | 1 | Front end consumed `tx_byte` |
| tx_byte | output | 8 | Next byte to transmit |
| busy | output | 1 | Programming cycle in progress |
| gpio_ld | output | 3 | One-hot load strobe: output, polarity, direction |
| gpio_ld_data | output | 8 | Data for the GPIO register load |

## Verification
Every possible address byte is tried with `a0`=1, so the address decode is checked exhaustively. The array is filled page by page and then read in one burst that runs past 0xFF. This shows the read pointer's full 8-bit increment apart from the write pointer's in-page wrap. A separate write starting four bytes below a page end proves the wrap. All 64 word values are written with the top bits set, which shows masking. All 32 mux-input values are latched and then changed before the read, which shows the snapshot timing. Write-protected, busy-time and reserved-code transactions are checked both by the acknowledge and busy pins and by reading memory back afterwards.

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq #(
  parameter int          PROG_CYCLES = 400000,
  parameter int          PAGE_BITS   = 4,
  parameter logic [5:0]  DEV_ID      = 6'b100111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a0,
  input  logic       wp,
  input  logic [4:0] mux_in,
  input  logic [7:0] gpio_in,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       rx_ack,
  input  logic       tx_take,
  output logic [7:0] tx_byte,
  output logic       busy,
  output logic [2:0] gpio_ld,
  output logic [7:0] gpio_ld_data
);
  localparam int PAGE  = 1 << PAGE_BITS;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam int UP_W  = 8 - PAGE_BITS;

  localparam logic [7:0] C_WR   = 8'h01, C_RD   = 8'h03, C_WW   = 8'h04, C_RW = 8'h06;
  localparam logic [7:0] C_MUX  = 8'h0C, C_LD_O = 8'h0F, C_LD_P = 8'h10;
  localparam logic [7:0] C_LD_D = 8'h11, C_STO  = 8'h12;

  typedef enum logic [2:0] {PH_IDLE, PH_SLV, PH_CMD, PH_ADDR, PH_DATA, PH_READ} phase_t;

  phase_t             phase;
  logic [7:0]         cmd, ptr;
  logic [4:0]         mux_lat;
  logic [5:0]         word, word_new;
  logic               word_pend;
  logic [7:0]         pbuf [PAGE];
  logic [PAGE-1:0]    pval;
  logic [UP_W-1:0]    pbase;
  logic [CNT_W-1:0]   cnt;
  logic               busy_q;
  logic [7:0]         mem [256];

  function automatic logic takes_addr(input logic [7:0] c);
    return c inside {C_WR, C_RD, C_WW, C_RW, C_LD_O, C_LD_P, C_LD_D, C_STO};
  endfunction

  wire addr_hit = (rx_byte[7:1] == {DEV_ID, a0});
  wire commit   = busy_q && (cnt == '0);
  wire [PAGE_BITS-1:0] lo_nx = ptr[PAGE_BITS-1:0] + 1'b1;

  assign busy   = busy_q;
  assign rx_ack = (phase == PH_SLV) ? (addr_hit && !busy_q) : (phase != PH_IDLE);

  always_comb begin
    case (cmd)
      C_RD, C_LD_O, C_LD_P, C_LD_D: tx_byte = mem[ptr];
      C_RW:                         tx_byte = {2'b00, word};
      C_MUX:                        tx_byte = {3'b000, mux_lat};
      default:                      tx_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      cmd          <= 8'hFF;
      ptr          <= '0;
      mux_lat      <= '0;
      word_new     <= '0;
      word_pend    <= 1'b0;
      pval         <= '0;
      pbase        <= '0;
      cnt          <= '0;
      busy_q       <= 1'b0;
      gpio_ld      <= '0;
      gpio_ld_data <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else begin
      gpio_ld <= '0;
      if (ev_start) begin
        phase <= PH_SLV;
      end else if (ev_stop) begin
        phase <= PH_IDLE;
        if (!busy_q) begin
          if ((|pval || word_pend) && !wp) begin
            busy_q <= 1'b1;
            cnt    <= CNT_W'(PROG_CYCLES - 1);
          end else begin
            pval      <= '0;
            word_pend <= 1'b0;
          end
        end
      end else if (rx_valid) begin
        case (phase)
          PH_SLV:
            if (addr_hit && !busy_q) phase <= rx_byte[0] ? PH_READ : PH_CMD;
            else                     phase <= PH_IDLE;
          PH_CMD: begin
            cmd <= rx_byte;
            if (rx_byte == C_MUX) mux_lat <= mux_in;
            phase <= takes_addr(rx_byte) ? PH_ADDR : PH_DATA;
          end
          PH_ADDR: begin
            ptr   <= rx_byte;
            pbase <= rx_byte[7:PAGE_BITS];
            phase <= PH_DATA;
            if (cmd inside {C_LD_O, C_LD_P, C_LD_D}) begin
              gpio_ld      <= (cmd == C_LD_O) ? 3'b001 : (cmd == C_LD_P) ? 3'b010 : 3'b100;
              gpio_ld_data <= mem[rx_byte];
            end
            if (cmd == C_STO) begin
              pbuf[rx_byte[PAGE_BITS-1:0]] <= gpio_in;
              pval[rx_byte[PAGE_BITS-1:0]] <= 1'b1;
            end
          end
          PH_DATA: begin
            if (cmd == C_WR) begin
              pbuf[ptr[PAGE_BITS-1:0]] <= rx_byte;
              pval[ptr[PAGE_BITS-1:0]] <= 1'b1;
              ptr <= {ptr[7:PAGE_BITS], lo_nx};
            end
            if (cmd == C_WW) begin
              word_new  <= rx_byte[5:0];
              word_pend <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (tx_take && phase == PH_READ && (cmd inside {C_RD, C_LD_O, C_LD_P, C_LD_D})) begin
        ptr <= ptr + 8'd1;
      end

      if (busy_q) begin
        if (cnt == '0) begin
          busy_q    <= 1'b0;
          pval      <= '0;
          word_pend <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (pval[i]) mem[{pbase, PAGE_BITS'(i)}] <= pbuf[i];
      if (word_pend) word <= word_new;
    end
  end

  // R4
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && phase == PH_SLV && busy_q) |-> !rx_ack);
  // R4
  busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(ev_stop));
  // R5
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && wp && !busy_q) |=> !busy_q);
  // R7
  ld_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpio_ld));
  // R7
  ld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gpio_ld) |-> $past(rx_valid));
endmodule

// File: tb/eeprom_cmd_seq_tb.sv
module eeprom_cmd_seq_tb;
  localparam int PROG = 8;
  localparam logic [7:0] AW = 8'h9E, AR = 8'h9F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a0 = 1'b1, wp = 1'b0;
  logic [4:0] mux_in = '0;
  logic [7:0] gpio_in = '0;
  logic ev_start = 0, ev_stop = 0, rx_valid = 0, tx_take = 0;
  logic [7:0] rx_byte = '0;
  logic rx_ack, busy;
  logic [7:0] tx_byte, gpio_ld_data;
  logic [2:0] gpio_ld;

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] model [256];

  eeprom_cmd_seq #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .a0(a0), .wp(wp), .mux_in(mux_in), .gpio_in(gpio_in),
    .ev_start(ev_start), .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ack(rx_ack), .tx_take(tx_take), .tx_byte(tx_byte), .busy(busy),
    .gpio_ld(gpio_ld), .gpio_ld_data(gpio_ld_data));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 199000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) ev_start = 1; @(negedge clk) ev_start = 0;
  endtask
  task automatic do_stop();
    @(negedge clk) ev_stop = 1; @(negedge clk) ev_stop = 0;
  endtask
  task automatic send(input logic [7:0] b, output logic ack);
    @(negedge clk) rx_byte = b; rx_valid = 1; #1 ack = rx_ack;
    @(negedge clk) rx_valid = 0;
  endtask
  task automatic recv(output logic [7:0] v);
    @(negedge clk) v = tx_byte; tx_take = 1;
    @(negedge clk) tx_take = 0;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask
  task automatic set_read(input logic [7:0] c, input logic [7:0] a);
    logic k;
    do_start(); send(AW, k); send(c, k); send(a, k);
    do_start(); send(AR, k);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  initial begin
    logic k;
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    // R11
    chk("R11 busy", busy, 0);
    chk("R11 gpio_ld", gpio_ld, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: every address byte
    for (int b = 0; b < 256; b++) begin
      do_start(); send(8'(b), k); do_stop();
      chk("R1 addr ack", k, (b >> 1) == 8'h4F);
    end
    a0 = 0;
    do_start(); send(8'h9C, k); chk("R1 a0=0 ack", k, 1); send(8'h01, k); do_stop();
    a0 = 1;

    // R2/R3/R4: fill array page by page
    for (int p = 0; p < 16; p++) begin
      do_start(); send(AW, k); send(8'h01, k); send(8'(p << 4), k);
      for (int i = 0; i < 16; i++) begin
        send(pat(p * 16 + i), k); model[p * 16 + i] = pat(p * 16 + i);
      end
      do_stop();
      if (p == 0) begin
        chk("R4 busy after stop", busy, 1);
        do_start(); send(AW, k); chk("R4 nack while busy", k, 0); do_stop();
        wait_idle(n);
      end else begin
        wait_idle(n);
        chk("R4 busy length", n, PROG);
      end
    end
    set_read(8'h03, 8'h00);
    for (int i = 0; i < 258; i++) begin
      recv(v); chk("R3 burst read", v, model[i % 256]);
    end
    do_stop();

    // R2: in-page wrap from 0x3C
    do_start(); send(AW, k); send(8'h01, k); send(8'h3C, k);
    for (int i = 0; i < 6; i++) begin
      send(8'hA0 + 8'(i), k); model[8'h30 + ((12 + i) % 16)] = 8'hA0 + 8'(i);
    end
    do_stop(); wait_idle(n);
    set_read(8'h03, 8'h30);
    for (int i = 0; i < 17; i++) begin
      recv(v); chk("R2 page wrap", v, model[8'h30 + i]);
    end
    do_stop();

    // R6: all word values with high bits set
    for (int w = 0; w < 64; w++) begin
      do_start(); send(AW, k); send(8'h04, k); send(8'hFF, k); send(8'(w) | 8'hC0, k);
      do_stop(); wait_idle(n);
      set_read(8'h06, 8'hFF); recv(v); do_stop();
      chk("R6 word read", v, w);
    end

    // R5: write protect
    wp = 1;
    do_start(); send(AW, k); send(8'h01, k); send(8'h50, k); send(8'h00, k); do_stop();
    chk("R5 no busy", busy, 0);
    do_start(); send(AW, k); send(8'h04, k); send(8'hFF, k); send(8'h15, k); do_stop();
    chk("R5 no busy word", busy, 0);
    wp = 0;
    set_read(8'h03, 8'h50); recv(v); do_stop();
    chk("R5 array kept", v, model[8'h50]);
    set_read(8'h06, 8'hFF); recv(v); do_stop();
    chk("R5 word kept", v, 63);

    // R7: GPIO loads
    for (int c = 0; c < 3; c++) begin
      do_start(); send(AW, k); send(8'h0F + 8'(c), k); send(8'h21 + 8'(c), k);
      chk("R7 ld strobe", gpio_ld, 1 << c);
      chk("R7 ld data", gpio_ld_data, model[8'h21 + c]);
      @(negedge clk);
      chk("R7 ld one cycle", gpio_ld, 0);
      do_stop();
    end

    // R8: GPIO input to array
    gpio_in = 8'hC5;
    do_start(); send(AW, k); send(8'h12, k); send(8'h77, k);
    gpio_in = 8'h00; send(8'h3A, k); do_stop(); wait_idle(n);
    model[8'h77] = 8'hC5;
    set_read(8'h03, 8'h76);
    for (int i = 0; i < 3; i++) begin recv(v); chk("R8 stored", v, model[8'h76 + i]); end
    do_stop();

    // R9: mux snapshot
    for (int m = 0; m < 32; m++) begin
      mux_in = 5'(m);
      do_start(); send(AW, k); send(8'h0C, k);
      mux_in = ~5'(m);
      do_start(); send(AR, k); recv(v); do_stop();
      chk("R9 mux latch", v, m);
    end

    // R10: other codes
    do_start(); send(AW, k); send(8'h0D, k); chk("R10 ack cmd", k, 1);
    send(8'h55, k); chk("R10 ack data", k, 1);
    do_start(); send(AR, k); recv(v); do_stop();
    chk("R10 reads FF", v, 8'hFF);
    chk("R10 no busy", busy, 0);
    do_start(); send(AW, k); send(8'h80, k); send(8'h00, k); send(8'h99, k); do_stop();
    chk("R10 no busy 80", busy, 0);
    set_read(8'h03, 8'h00); recv(v); do_stop();
    chk("R10 array kept", v, model[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule